// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol core of a byte-wide serial memory that sits on a two-wire bus as a slave. It does not sample the pads. A bus front-end hands it single-cycle pulses for START, STOP, SCL rising and SCL falling, together with the sampled data line. From these the engine shifts in and checks the control byte. It loads a word address into its one address pointer and serves current-address, random and sequential reads. It drives an open-drain pull-down enable for acknowledge bits and read data.

The storage array lives inside the engine as a register model with a synchronous read port. Writes do not go straight into it. Each received data byte is passed on with its target address to a separate page-write controller. A STOP after write data tells that controller to commit. The controller then owns the array write port and reports when it is busy. While it is busy the engine acknowledges nothing, so a bus master can poll for completion.

Top module: `eep_slave_engine`

## Requirements
- R1: After reset, `sda_oe`, `wr_valid` and `wr_commit` are low.
- R2: A control byte is acknowledged only when its upper four bits are 1010. Bits 3..1 are ignored. Bit 0 selects the transfer: 1 reads, 0 writes. Any other upper nibble gets no acknowledge, and SDA stays released until the next START or STOP.
- R3: For each byte it accepts (control, word address or write data), the engine pulls SDA low during the ninth SCL clock. It releases SDA at the SCL fall that ends that clock.
- R4: If `wr_busy` is high when the eighth bit of a control byte completes, no acknowledge is given, whether the byte requests a read or a write.
- R5: In a write, the byte after the control byte loads the pointer; with a 128-entry array its bit 7 is ignored. Each later byte appears exactly once as a one-cycle `wr_valid` pulse, with `wr_addr` equal to the pointer. The pointer's low three bits then advance modulo 8 and its upper bits stay the same.
- R6: A STOP that ends a write carrying at least one data byte gives a one-cycle `wr_commit` pulse. A STOP after only an address byte gives no pulse, and neither does a repeated START.
- R7: Read data leaves MSB first. Each bit is placed after an SCL fall: a 0 pulls SDA low and a 1 releases it. SDA is released during the master's acknowledge clock.
- R8: A current-address read returns the byte at the last accessed address plus one.
- R9: The pointer written by a write-mode address byte survives a repeated START, so the following read returns that location.
- R10: When the master acknowledges a read byte, the next sequential byte follows. The pointer wraps from the top address to 0.
- R11: When the master does not acknowledge a read byte, SDA stays released for all later clocks until a START or STOP.
- R12: A START or STOP in any state releases SDA by the next cycle. A STOP returns the engine to idle; a START returns it to control-byte matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | One-cycle pulse: START seen on the bus |
| stop_evt | input | 1 | One-cycle pulse: STOP seen on the bus |
| scl_rise | input | 1 | One-cycle pulse: SCL rising edge |
| scl_fall | input | 1 | One-cycle pulse: SCL falling edge |
| sda_in | input | 1 | Sampled SDA level, used at `scl_rise` |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| wr_busy | input | 1 | Page-write controller is programming the array |
| wr_valid | output | 1 | One-cycle pulse: a write data byte is presented |
| wr_addr | output | log2(DEPTH) | Target address of the presented byte |
| wr_data | output | 8 | Presented write data byte |
| wr_commit | output | 1 | One-cycle pulse: STOP ended a write with data |
| mem_we | input | 1 | Array write strobe from the page-write controller |
| mem_waddr | input | log2(DEPTH) | Array write address |
| mem_wdata | input | 8 | Array write data |

## Verification
The hardest case to reach from the ports is the acknowledge decision on a control byte while a write is still in progress. It needs a full write transaction, a STOP, the resulting commit, and a poll inside the busy window. The bench plays the page-write controller. It records each presented byte, raises `wr_busy` after the commit, and polls with both read and write control bytes to check that neither is acknowledged. Only after that does it program the recorded bytes into the array and drop busy. A bounded read-back then checks the ten-byte page wrap and the overwrite order through the bus. Sequential reads sweep the whole array plus a wrap, built on a bench-computed pattern.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_HOLD
  } eep_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam logic [3:0] ACK_CNT  = 4'd8;
  localparam logic [3:0] SLOT_END = 4'd9;
endpackage

// File: rtl/eep_store.sv
module eep_store #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_ptr.sv
module eep_ptr #(
  parameter int AW = 8,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          seq_inc,
  input  logic          page_inc,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LOW_MASK = AW'((1 << PW) - 1);

  logic [AW-1:0] seq_next;
  logic [AW-1:0] page_next;

  assign seq_next  = ptr + 1'b1;
  assign page_next = (ptr & ~LOW_MASK) | (seq_next & LOW_MASK);

  always_ff @(posedge clk) begin
    if (rst)           ptr <= '0;
    else if (ld)       ptr <= ld_val;
    else if (seq_inc)  ptr <= seq_next;
    else if (page_inc) ptr <= page_next;
  end

  AST_PAGE_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
    (page_inc && !ld && !seq_inc) |=> ((ptr & ~LOW_MASK) == ($past(ptr) & ~LOW_MASK))); // R5
  AST_SEQ_WRAP: assert property (@(posedge clk) disable iff (rst)
    (seq_inc && !ld && (ptr == {AW{1'b1}})) |=> (ptr == '0)); // R10
endmodule

// File: rtl/eep_txsr.sv
module eep_txsr (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] din,
  input  logic       shift,
  output logic       msb
);
  logic [7:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= 8'hFF;
    else if (load)  sr <= {din[6:0], 1'b1};
    else if (shift) sr <= {sr[6:0], 1'b1};
  end

  assign msb = sr[7];
endmodule

// File: rtl/eep_slave_engine.sv
module eep_slave_engine #(
  parameter int DEPTH      = 256,
  parameter int PAGE_BYTES = 8,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic          wr_busy,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_commit,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_waddr,
  input  logic [7:0]    mem_wdata
);
  import eep_pkg::*;

  localparam int PW = $clog2(PAGE_BYTES);

  eep_state_e    st;
  logic [3:0]    cnt;
  logic [7:0]    rx;
  logic          acked;
  logic          rd_mode;
  logic          got_data;
  logic          mack;

  logic          bus_evt;
  logic          rise_ok;
  logic          fall_ok;
  logic          fall8;
  logic          fall9;
  logic          ctrl_hit;
  logic          ptr_ld;
  logic          page_step;
  logic          tx_load;
  logic          tx_shift;
  logic          tx_msb;
  logic [AW-1:0] ptr;
  logic [AW-1:0] addr_byte;
  logic [7:0]    rd_q;

  assign bus_evt   = start_evt | stop_evt;
  assign rise_ok   = scl_rise & ~bus_evt;
  assign fall_ok   = scl_fall & ~bus_evt;
  assign fall8     = fall_ok && (cnt == ACK_CNT);
  assign fall9     = fall_ok && (cnt == SLOT_END);
  assign ctrl_hit  = (rx[7:4] == DEV_CODE) && !wr_busy;
  assign addr_byte = rx[AW-1:0];
  assign ptr_ld    = (st == ST_ADDR) && fall8;
  assign page_step = (st == ST_WDATA) && fall8;
  assign tx_load   = fall9 && (((st == ST_CTRL) && acked && rd_mode) ||
                               ((st == ST_RDATA) && mack));
  assign tx_shift  = (st == ST_RDATA) && fall_ok && (cnt >= 4'd1) && (cnt <= 4'd7);

  eep_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ptr),
    .rdata (rd_q)
  );

  eep_ptr #(.AW(AW), .PW(PW)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .ld       (ptr_ld),
    .ld_val   (addr_byte),
    .seq_inc  (tx_load),
    .page_inc (page_step),
    .ptr      (ptr)
  );

  eep_txsr u_txsr (
    .clk   (clk),
    .rst   (rst),
    .load  (tx_load),
    .din   (rd_q),
    .shift (tx_shift),
    .msb   (tx_msb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      rx        <= '0;
      acked     <= 1'b0;
      rd_mode   <= 1'b0;
      got_data  <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      wr_commit <= 1'b0;
      if (stop_evt) begin
        if ((st == ST_WDATA) && got_data) wr_commit <= 1'b1;
        st       <= ST_IDLE;
        cnt      <= '0;
        sda_oe   <= 1'b0;
        got_data <= 1'b0;
      end else if (start_evt) begin
        st       <= ST_CTRL;
        cnt      <= '0;
        sda_oe   <= 1'b0;
        got_data <= 1'b0;
      end else begin
        case (st)
          ST_CTRL, ST_ADDR, ST_WDATA: begin
            if (rise_ok && (cnt < SLOT_END)) begin
              if (cnt < ACK_CNT) rx <= {rx[6:0], sda_in};
              cnt <= cnt + 4'd1;
            end
            if (fall8) begin
              if (st == ST_CTRL) begin
                acked   <= ctrl_hit;
                rd_mode <= rx[0];
                sda_oe  <= ctrl_hit;
              end else begin
                acked  <= 1'b1;
                sda_oe <= 1'b1;
                if (st == ST_WDATA) begin
                  wr_valid <= 1'b1;
                  wr_addr  <= ptr;
                  wr_data  <= rx;
                  got_data <= 1'b1;
                end
              end
            end
            if (fall9) begin
              cnt    <= '0;
              sda_oe <= 1'b0;
              if (!acked) begin
                st <= ST_HOLD;
              end else if (st == ST_CTRL) begin
                if (rd_mode) begin
                  st     <= ST_RDATA;
                  sda_oe <= ~rd_q[7];
                end else begin
                  st <= ST_ADDR;
                end
              end else if (st == ST_ADDR) begin
                st <= ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (rise_ok && (cnt < SLOT_END)) begin
              if (cnt == ACK_CNT) mack <= ~sda_in;
              cnt <= cnt + 4'd1;
            end
            if (tx_shift) sda_oe <= ~tx_msb;
            if (fall8)    sda_oe <= 1'b0;
            if (fall9) begin
              cnt <= '0;
              if (mack) begin
                sda_oe <= ~rd_q[7];
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe); // R12
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> !sda_oe); // R12
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_CTRL) && fall8 && wr_busy) |=> !sda_oe); // R4
  AST_MASTER_SLOT_FREE: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_RDATA) && (cnt == SLOT_END)) |-> !sda_oe); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid); // R5
  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> $past(stop_evt)); // R6
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HOLD) |-> !sda_oe); // R11
endmodule

// File: tb/test_eep_slave_engine.sv
module test_eep_slave_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;
  localparam int AW         = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_evt = 1'b0;
  logic          stop_evt  = 1'b0;
  logic          scl_rise  = 1'b0;
  logic          scl_fall  = 1'b0;
  logic          m_rel     = 1'b1;
  logic          wr_busy   = 1'b0;
  logic          mem_we    = 1'b0;
  logic [AW-1:0] mem_waddr = '0;
  logic [7:0]    mem_wdata = '0;
  logic          sda_in;
  logic          sda_oe;
  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          wr_commit;

  int nvec  = 0;
  int nfail = 0;
  int ncap  = 0;
  int ncommit = 0;
  logic [7:0]    model    [DEPTH];
  logic [AW-1:0] cap_addr [32];
  logic [7:0]    cap_data [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_in = m_rel & ~sda_oe;

  eep_slave_engine #(.DEPTH(DEPTH), .PAGE_BYTES(8)) i_eep_slave_engine (
    .clk       (clk),
    .rst       (rst),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_in    (sda_in),
    .sda_oe    (sda_oe),
    .wr_busy   (wr_busy),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_commit (wr_commit),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata)
  );

  always @(negedge clk) begin
    if (wr_valid && ncap < 32) begin
      cap_addr[ncap] = wr_addr;
      cap_data[ncap] = wr_data;
      ncap++;
    end
    if (wr_commit) ncommit++;
  end

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_start();
    m_rel = 1'b1;
    start_evt = 1'b1; tick(1); start_evt = 1'b0; tick(2);
  endtask

  task automatic do_stop();
    m_rel = 1'b1;
    stop_evt = 1'b1; tick(1); stop_evt = 1'b0; tick(2);
  endtask

  task automatic bus_bit(input logic mb, output logic seen);
    m_rel = mb; tick(2);
    seen = sda_in;
    scl_rise = 1'b1; tick(1); scl_rise = 1'b0; tick(2);
    scl_fall = 1'b1; tick(1); scl_fall = 1'b0; tick(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      b[i] = s;
    end
    bus_bit(!mack, s);
    if (!mack) chk("R7 master ack clock released", int'(s), 1);
  endtask

  task automatic set_addr(input logic [7:0] a);
    logic ack;
    do_start();
    send_byte(8'hA0, ack); chk("R3 write control ack", int'(ack), 1);
    send_byte(a, ack);     chk("R3 address ack", int'(ack), 1);
  endtask

  task automatic read_ctl();
    logic ack;
    do_start();
    send_byte(8'hA1, ack); chk("R9 read control ack", int'(ack), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic       ack;
    logic       s;
    logic [7:0] b;
    int         base;

    tick(4);
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    chk("R1 wr_valid after reset", int'(wr_valid), 0);
    chk("R1 wr_commit after reset", int'(wr_commit), 0);
    rst = 1'b0;
    tick(2);

    for (int a = 0; a < DEPTH; a++) begin
      mem_we = 1'b1; mem_waddr = AW'(a); mem_wdata = pat(a); model[a] = pat(a);
      tick(1);
    end
    mem_we = 1'b0;
    tick(2);

    // R2: sweep every upper nibble in write mode
    for (int n = 0; n < 16; n++) begin
      do_start();
      send_byte({4'(n), 3'b101, 1'b0}, ack);
      chk("R2 device code match", int'(ack), (n == 10) ? 1 : 0);
      send_byte(8'h00, ack);
      chk("R2 follow-up byte ack", int'(ack), (n == 10) ? 1 : 0);
      do_stop();
    end
    chk("R6 no commit without data", ncommit, 0);

    // R2 / R8: select bits ignored, current-address reads step from 0
    for (int sel = 0; sel < 8; sel++) begin
      do_start();
      send_byte({4'hA, 3'(sel), 1'b1}, ack);
      chk("R2 select bits ignored", int'(ack), 1);
      recv_byte(1'b0, b);
      chk("R8 current address read", int'(b), int'(model[sel]));
      do_stop();
    end

    // R9 / R8 / R11: random read then current-address read
    for (int a = 3; a < DEPTH; a += 23) begin
      set_addr(8'(a));
      read_ctl();
      recv_byte(1'b0, b);
      chk("R9 random read data", int'(b), int'(model[a]));
      for (int i = 0; i < 9; i++) begin
        bus_bit(1'b1, s);
        chk("R11 released after master nack", int'(s), 1);
      end
      do_stop();
      do_start();
      send_byte(8'hA1, ack);
      recv_byte(1'b0, b);
      chk("R8 next address after random", int'(b), int'(model[(a + 1) % DEPTH]));
      do_stop();
    end

    // R10 / R7: sequential read across the whole array plus wrap
    set_addr(8'h05);
    read_ctl();
    for (int k = 0; k < 260; k++) begin
      recv_byte(k != 259, b);
      chk("R10 sequential read with wrap", int'(b), int'(model[(5 + k) % DEPTH]));
    end
    do_stop();

    // R5 / R3 / R6: ten-byte page write from 0x3D
    ncap = 0;
    base = ncommit;
    set_addr(8'h3D);
    for (int k = 0; k < 10; k++) begin
      send_byte(8'(8'h5A ^ (k * 29)), ack);
      chk("R3 data byte ack", int'(ack), 1);
    end
    do_stop();
    tick(2);
    chk("R5 presented byte count", ncap, 10);
    chk("R6 commit after write stop", ncommit, base + 1);
    for (int k = 0; k < 10; k++) begin
      chk("R5 page wrapped address", int'(cap_addr[k]), 32'h38 | ((32'h3D + k) & 7));
      chk("R5 presented data", int'(cap_data[k]), int'(8'(8'h5A ^ (k * 29))));
    end

    // R4: busy window, poll with both directions
    wr_busy = 1'b1;
    do_start();
    send_byte(8'hA0, ack); chk("R4 write poll while busy", int'(ack), 0);
    do_stop();
    do_start();
    send_byte(8'hA1, ack); chk("R4 read poll while busy", int'(ack), 0);
    bus_bit(1'b1, s);      chk("R4 line released after nack", int'(s), 1);
    do_stop();
    for (int k = 0; k < ncap; k++) begin
      mem_we = 1'b1; mem_waddr = cap_addr[k]; mem_wdata = cap_data[k];
      model[cap_addr[k]] = cap_data[k];
      tick(1);
    end
    mem_we = 1'b0;
    wr_busy = 1'b0;
    do_start();
    send_byte(8'hA0, ack); chk("R4 poll acked when idle", int'(ack), 1);
    do_stop();
    chk("R6 no commit for empty poll", ncommit, base + 1);
    set_addr(8'h38);
    read_ctl();
    for (int k = 0; k < 8; k++) begin
      recv_byte(k != 7, b);
      chk("R5 page readback", int'(b), int'(model[8'h38 + k]));
    end
    do_stop();

    // R6: repeated START after data gives no commit
    base = ncommit;
    set_addr(8'h10);
    send_byte(8'hEE, ack);
    read_ctl();
    recv_byte(1'b0, b);
    do_stop();
    tick(2);
    chk("R6 repeated start no commit", ncommit, base);

    // R12: STOP while acknowledging, START in mid-read
    do_start();
    for (int i = 7; i >= 0; i--) bus_bit(1'(8'hA0 >> i), s);
    chk("R3 ack driven after eighth bit", int'(sda_oe), 1);
    do_stop();
    chk("R12 stop releases line", int'(sda_oe), 0);
    set_addr(8'h80);
    read_ctl();
    for (int i = 0; i < 3; i++) bus_bit(1'b1, s);
    do_start();
    chk("R12 start releases line", int'(sda_oe), 0);
    send_byte(8'hA1, ack);
    chk("R12 control matched after restart", int'(ack), 1);
    recv_byte(1'b0, b);
    chk("R12 pointer advanced by aborted read", int'(b), int'(model[8'h81]));
    do_stop();

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule